// File: doc/BRIEF.md
# Single-Lane SPI Flash Master Serial Engine

This block is the serial shifter of a flash controller. It takes 32-bit words offered on a valid/ready transmit stream and shifts each word out on a single data line, most significant bit first. It captures the same number of bits from the return line and offers every completed word on a valid/ready receive stream. A register write port sets the clock divider, the clock polarity and phase, chip-select control and start control. A separate enable register gates the whole engine.

The serial clock comes from the reference clock. Its half period is a power of two of reference cycles, chosen by a 3-bit exponent code, so the fastest serial clock is half the reference clock. The chip select is normally asserted for each word on its own. Software can instead hold it at a level of its own choosing, so that a command, an address and data travel under one select. Transmission starts on its own whenever a word is offered, unless manual start is selected. In manual start, queued words wait for an explicit launch.

Transmit back-pressure: `tx_ready` is high only while the engine is idle and allowed to start. A word is taken in the cycle where `tx_valid` and `tx_ready` are both high. Receive back-pressure: once `rx_valid` rises, it stays high with `rx_data` stable until `rx_ready` is seen high. Until then the engine takes no further transmit word.

Top module: `qspi_serial_engine`

## Requirements
- R1: While reset is held, `cs_n` is 1, `sclk` is 0, `mosi` is 0, `tx_ready` is 0 and `rx_valid` is 0.
- R2: The configuration word's bits [5:3] hold a code c. Each serial clock half period lasts 2^c reference cycles: code 0 gives half the reference rate and code 7 divides by 256.
- R3: Configuration bit 1 sets the idle clock level (CPOL). Configuration bit 2 sets the phase (CPHA). With CPHA=0, data is captured on the leading edge and changed on the trailing edge. With CPHA=1, data is changed on the leading edge and captured on the trailing edge. All four combinations transfer data correctly.
- R4: Each transmit word is sent most significant bit first. Exactly one receive word is produced per transmit word. That receive word holds the 32 captured bits, with the first captured bit in bit 31.
- R5: With configuration bit 14 clear, `cs_n` goes low for each word and returns high between words. With bit 14 set, `cs_n` follows configuration bit 10, where 0 selects the device, and stays there between words.
- R6: With configuration bit 15 set, no word is taken until a configuration write carries both bit 15 and bit 16. The engine then takes queued words until it is idle with no word offered, and after that it waits for the next such write. Bit 16 always reads back as 0.
- R7: No word is taken and `sclk` stays at its idle level in any of these cases: enable register bit 0 is 0, configuration bit 0 (master) is 0, or configuration bits [7:6] are not 11 (32-bit words).
- R8: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high, `rx_data` stays unchanged and `tx_ready` stays 0.
- R9: Every word produces exactly 64 serial clock transitions. Between words, `sclk` rests at the level of configuration bit 1.
- R10: Register address 0 reads back the configuration word. Address 1 reads back the enable bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects configuration, 1 selects enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine takes the offered word |
| tx_data | input | WORD_W | Transmit word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer accepts the received word |
| rx_data | output | WORD_W | Received word |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest state to reach from the ports is a manual-start burst whose launch arrives while words are already waiting on the stream. Correct behaviour here means the engine drains exactly the queued words and then disarms. The bench holds `tx_valid` high with a word for a long stretch before writing the launch bit, and feeds the following words back to back. It then offers one more word and confirms that nothing is taken until a second launch. Receive back-pressure is reached by holding `rx_ready` low across a two-word burst, which leaves the second word parked on the transmit stream while the first is held.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  localparam int REG_W        = 32;
  localparam int CB_MASTER    = 0;
  localparam int CB_CPOL      = 1;
  localparam int CB_CPHA      = 2;
  localparam int CB_DIV_LO    = 3;
  localparam int CB_WID_LO    = 6;
  localparam int CB_CS_LEVEL  = 10;
  localparam int CB_CS_MANUAL = 14;
  localparam int CB_START_MAN = 15;
  localparam int CB_START_GO  = 16;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_PUSH  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/qspi_cfg_regs.sv
module qspi_cfg_regs
  import qspi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [REG_W-1:0] cfg_q,
  output logic             en_q,
  output logic             start_req
);
  localparam logic [REG_W-1:0] GO_MASK = REG_W'(1) << CB_START_GO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      en_q  <= 1'b0;
    end else if (reg_we) begin
      if (!reg_addr) cfg_q <= reg_wdata & ~GO_MASK;
      else           en_q  <= reg_wdata[0];
    end
  end

  // launch request: manual-start write that also carries the go bit
  assign start_req = reg_we & ~reg_addr & reg_wdata[CB_START_MAN] & reg_wdata[CB_START_GO];
  assign reg_rdata = reg_addr ? {{(REG_W-1){1'b0}}, en_q} : cfg_q;
endmodule

// File: rtl/qspi_clkdiv.sv
module qspi_clkdiv #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = CNT_W'((32'd1 << code) - 32'd1);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/qspi_shifter.sv
module qspi_shifter
  import qspi_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [CODE_W-1:0] code_in,
  input  logic              tick,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  input  logic              miso,
  output logic              mosi,
  output logic              sclk,
  output logic [CODE_W-1:0] code_q,
  output logic              busy,
  output logic              idle,
  output logic              pop
);
  localparam int EDGES  = 2 * WORD_W;
  localparam int EDGE_W = $clog2(EDGES);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

  eng_state_t        state_q;
  logic              cpol_q, cpha_q;
  logic [EDGE_W-1:0] edge_q;
  logic [WORD_W-1:0] tx_sh, rx_sh, rx_q, rx_nxt;
  logic              lead, out_edge;

  assign idle     = (state_q == ST_IDLE);
  assign busy     = (state_q == ST_SHIFT);
  assign rx_valid = (state_q == ST_PUSH);
  assign rx_data  = rx_q;
  assign tx_ready = idle & go;
  assign pop      = tx_ready & tx_valid;

  // even edge index = leading edge; the launch edge depends on phase
  assign lead     = ~edge_q[0];
  assign out_edge = (lead == cpha_q);
  assign rx_nxt   = (tick && !out_edge) ? {rx_sh[WORD_W-2:0], miso} : rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cpol_q  <= 1'b0;
      cpha_q  <= 1'b0;
      code_q  <= '0;
      edge_q  <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_q    <= '0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          sclk <= cpol;
          if (pop) begin
            state_q <= ST_SHIFT;
            cpol_q  <= cpol;
            cpha_q  <= cpha;
            code_q  <= code_in;
            edge_q  <= '0;
            rx_sh   <= '0;
            if (cpha) begin
              tx_sh <= tx_data;
            end else begin
              tx_sh <= tx_data << 1;
              mosi  <= tx_data[WORD_W-1];
            end
          end
        end
        ST_SHIFT: begin
          rx_sh <= rx_nxt;
          if (tick) begin
            sclk   <= ~sclk;
            edge_q <= edge_q + EDGE_W'(1);
            if (out_edge) begin
              mosi  <= tx_sh[WORD_W-1];
              tx_sh <= tx_sh << 1;
            end
            if (edge_q == LAST_EDGE) begin
              rx_q    <= rx_nxt;
              state_q <= ST_PUSH;
            end
          end
        end
        ST_PUSH: begin
          if (rx_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qspi_serial_engine.sv
module qspi_serial_engine
  import qspi_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  logic [REG_W-1:0]  cfg_q;
  logic              en_q, start_req;
  logic              busy, idle, pop, tick, armed_q, go, width_ok;
  logic [CODE_W-1:0] code_q;

  qspi_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_q(cfg_q),
    .en_q(en_q), .start_req(start_req)
  );

  assign width_ok = (cfg_q[CB_WID_LO +: 2] == 2'b11);
  assign go = en_q & cfg_q[CB_MASTER] & width_ok & (~cfg_q[CB_START_MAN] | armed_q);

  // manual start: armed by a launch write, disarmed once idle with nothing offered
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   armed_q <= 1'b0;
    else if (start_req)           armed_q <= 1'b1;
    else if (!cfg_q[CB_START_MAN]) armed_q <= 1'b0;
    else if (idle && !tx_valid)   armed_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cs_n <= 1'b1;
    else if (cfg_q[CB_CS_MANUAL])  cs_n <= cfg_q[CB_CS_LEVEL];
    else                           cs_n <= ~(busy | pop);
  end

  qspi_clkdiv #(.CODE_W(CODE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .code(code_q), .tick(tick)
  );

  qspi_shifter #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(go),
    .cpol(cfg_q[CB_CPOL]), .cpha(cfg_q[CB_CPHA]),
    .code_in(cfg_q[CB_DIV_LO +: CODE_W]), .tick(tick),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .miso(miso), .mosi(mosi), .sclk(sclk), .code_q(code_q),
    .busy(busy), .idle(idle), .pop(pop)
  );
endmodule

// File: rtl/qspi_serial_engine_sva.sv
module qspi_serial_engine_sva #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg,
  input logic              en,
  input logic              busy,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [WORD_W-1:0] rx_data,
  input logic              sclk,
  input logic              cs_n
);
  p_hold_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || !cfg[0]) |-> !tx_ready);

  p_cs_manual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg[14]) |-> cs_n == $past(cfg[10]));

  p_push_after_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(busy));

  p_pop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !busy && !rx_valid);

  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> ($past(busy) || sclk == $past(cfg[1])));
endmodule

bind qspi_serial_engine qspi_serial_engine_sva #(.WORD_W(WORD_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .en(en_q), .busy(busy),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .sclk(sclk), .cs_n(cs_n)
);

// File: tb/qspi_serial_engine_bench.sv
`timescale 1ns/1ps
module qspi_serial_engine_bench;
  localparam logic [31:0] CFG_BASE = 32'h0000_00C1; // master + 32-bit width
  localparam logic [31:0] B_CPOL = 32'h2, B_CPHA = 32'h4;
  localparam logic [31:0] B_CSLV = 32'h400, B_CSMAN = 32'h4000;
  localparam logic [31:0] B_SMAN = 32'h8000, B_GO = 32'h1_0000;

  logic clk = 1'b0, rst_n;
  logic reg_we = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b1;
  logic [31:0] tx_data = '0, rx_data;
  logic sclk, cs_n, mosi, miso = 1'b0;

  qspi_serial_engine u_qspi_serial_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_tx[$], exp_rx[$];
  int drv_k = 0, s_k = 0, tx_seq = 0, pops = 0, edges = 0, cs_rises = 0;
  logic b_cpol = 1'b0, b_cpha = 1'b0, burst_busy = 1'b0, finished = 1'b0;

  function automatic logic [31:0] slave_word(int k);
    return (32'(k + 1) * 32'h9E37_79B9) ^ 32'h0F0F_F0F0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_addr = 1'b0;
  endtask

  task automatic send_burst(input int n);
    burst_busy = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = 32'h8000_0001 ^ (32'(tx_seq) * 32'h0123_4567);
      tx_seq++;
      @(negedge clk); tx_valid = 1'b1; tx_data = w;
      forever begin
        if (tx_ready) begin @(posedge clk); break; end
        @(negedge clk);
      end
      exp_tx.push_back(w);
      exp_rx.push_back(slave_word(drv_k));
      drv_k++;
    end
    @(negedge clk); tx_valid = 1'b0;
    burst_busy = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!burst_busy && exp_tx.size() == 0 && exp_rx.size() == 0 && !rx_valid) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic measure_half(input int exp_c, input string req);
    logic prev;
    int cnt;
    prev = sclk;
    for (int i = 0; i < 2000 && sclk == prev; i++) @(negedge clk);
    prev = sclk; cnt = 0;
    do begin @(negedge clk); cnt++; end while (sclk == prev && cnt < 2000);
    check(cnt == exp_c, req, 32'(cnt), 32'(exp_c));
  endtask

  // handshake counter
  always @(posedge clk) if (rst_n === 1'b1 && tx_valid && tx_ready) pops++;
  always @(posedge cs_n) if (rst_n === 1'b1) cs_rises++;

  // monitor: compares received words against the scoreboard (R4)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rx_valid && rx_ready) begin
      if (exp_rx.size() == 0) check(1'b0, "R4 unexpected rx word", rx_data, 32'h0);
      else begin
        logic [31:0] e;
        e = exp_rx.pop_front();
        check(rx_data == e, "R4/R3 rx word", rx_data, e);
      end
    end
  end

  // serial device model
  logic [31:0] s_sh = '0, m_sh = '0;
  int s_cnt = 0, m_cnt = 0;
  always @(negedge cs_n) begin
    if (rst_n === 1'b1) begin
      s_cnt = 0; m_cnt = 0; s_sh = slave_word(s_k);
      if (!b_cpha) miso = s_sh[31];
    end
  end
  always @(sclk) begin
    if (cs_n === 1'b0 && rst_n === 1'b1) begin
      logic lead;
      lead = (sclk !== b_cpol);
      edges++;
      if (lead == b_cpha) begin
        if (b_cpha) miso = s_sh[31];
        s_sh = s_sh << 1; s_cnt++;
        if (s_cnt == 32) begin s_k++; s_sh = slave_word(s_k); s_cnt = 0; end
        if (!b_cpha) miso = s_sh[31];
      end else begin
        m_sh = {m_sh[30:0], mosi}; m_cnt++;
        if (m_cnt == 32) begin
          m_cnt = 0;
          if (exp_tx.size() == 0) check(1'b0, "R4 unexpected mosi word", m_sh, 32'h0);
          else begin
            logic [31:0] e;
            e = exp_tx.pop_front();
            check(m_sh == e, "R4/R3 mosi word", m_sh, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(cs_n === 1'b1 && sclk === 1'b0 && mosi === 1'b0, "R1 pins in reset",
          {29'b0, cs_n, sclk, mosi}, 32'h4);
    check(tx_ready === 1'b0 && rx_valid === 1'b0, "R1 handshakes in reset",
          {30'b0, tx_ready, rx_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10 readback; bit 16 never stored (R6)
    wr(1'b0, CFG_BASE | B_GO | 32'h0000_0018);
    reg_addr = 1'b0; #1;
    check(reg_rdata == (CFG_BASE | 32'h18), "R10/R6 config readback", reg_rdata, CFG_BASE | 32'h18);
    wr(1'b1, 32'h1);
    reg_addr = 1'b1; #1;
    check(reg_rdata == 32'h1, "R10 enable readback", reg_rdata, 32'h1);
    reg_addr = 1'b0;

    // mode 0, code 0: three words, auto select
    b_cpol = 0; b_cpha = 0;
    wr(1'b0, CFG_BASE);
    begin
      int e0, c0;
      e0 = edges; c0 = cs_rises;
      fork send_burst(3); join_none
      measure_half(1, "R2 half period code0");
      wait_idle();
      check(edges - e0 == 192, "R9 edges for three words", 32'(edges - e0), 32'd192);
      check(cs_rises - c0 == 3, "R5 select released per word", 32'(cs_rises - c0), 32'd3);
      check(sclk == 1'b0 && cs_n == 1'b1, "R9 idle after mode0", {30'b0, sclk, cs_n}, 32'h1);
    end

    // remaining modes; code 2 in mode 3
    b_cpol = 0; b_cpha = 1;
    wr(1'b0, CFG_BASE | B_CPHA | (32'd1 << 3));
    fork send_burst(2); join_none
    measure_half(2, "R2 half period code1");
    wait_idle();
    b_cpol = 1; b_cpha = 0;
    wr(1'b0, CFG_BASE | B_CPOL);
    repeat (2) @(negedge clk);
    check(sclk == 1'b1, "R9 idle level follows CPOL", sclk, 32'h1);
    fork send_burst(2); join_none
    wait_idle();
    b_cpol = 1; b_cpha = 1;
    wr(1'b0, CFG_BASE | B_CPOL | B_CPHA | (32'd2 << 3));
    fork send_burst(2); join_none
    measure_half(4, "R2 half period code2");
    wait_idle();
    check(sclk == 1'b1, "R9 idle level mode3", sclk, 32'h1);

    // R7 gating cases
    b_cpol = 0; b_cpha = 0;
    for (int g = 0; g < 3; g++) begin
      int p0;
      logic ok;
      if (g == 0) begin wr(1'b0, CFG_BASE); wr(1'b1, 32'h0); end
      if (g == 1) begin wr(1'b1, 32'h1); wr(1'b0, CFG_BASE & ~32'h1); end
      if (g == 2) wr(1'b0, (CFG_BASE & ~32'hC0) | 32'h80);
      p0 = pops; ok = 1'b1;
      @(negedge clk); tx_valid = 1'b1; tx_data = 32'hDEAD_BEEF;
      repeat (150) begin @(negedge clk); if (tx_ready || sclk || !cs_n) ok = 1'b0; end
      tx_valid = 1'b0;
      check(ok && pops == p0, "R7 gated engine stays idle", 32'(pops - p0), 32'h0);
    end
    wr(1'b0, CFG_BASE);

    // R6 manual start
    b_cpol = 0; b_cpha = 0;
    wr(1'b0, CFG_BASE | B_SMAN);
    begin
      int p0;
      p0 = pops;
      fork send_burst(3); join_none
      repeat (120) @(negedge clk);
      check(pops == p0, "R6 no take before launch", 32'(pops - p0), 32'h0);
      wr(1'b0, CFG_BASE | B_SMAN | B_GO);
      wait_idle();
      check(pops - p0 == 3, "R6 launch drains queue", 32'(pops - p0), 32'd3);
      p0 = pops;
      fork send_burst(1); join_none
      repeat (120) @(negedge clk);
      check(pops == p0, "R6 disarmed after drain", 32'(pops - p0), 32'h0);
      wr(1'b0, CFG_BASE | B_SMAN | B_GO);
      wait_idle();
      check(pops - p0 == 1, "R6 second launch", 32'(pops - p0), 32'd1);
    end

    // R5 manual select
    wr(1'b0, CFG_BASE | B_CSMAN | B_CSLV);
    repeat (2) @(negedge clk);
    check(cs_n == 1'b1, "R5 manual select high", cs_n, 32'h1);
    wr(1'b0, CFG_BASE | B_CSMAN);
    repeat (2) @(negedge clk);
    check(cs_n == 1'b0, "R5 manual select low", cs_n, 32'h0);
    begin
      logic held;
      held = 1'b1;
      fork send_burst(2); join_none
      repeat (20) @(negedge clk);
      while (burst_busy || exp_rx.size() != 0) begin @(negedge clk); if (cs_n) held = 1'b0; end
      check(held, "R5 select held across words", {31'b0, held}, 32'h1);
    end
    wr(1'b0, CFG_BASE | B_CSMAN | B_CSLV);
    repeat (2) @(negedge clk);
    check(cs_n == 1'b1, "R5 manual release", cs_n, 32'h1);

    // R8 receive back-pressure
    wr(1'b0, CFG_BASE);
    rx_ready = 1'b0;
    begin
      logic [31:0] held_d;
      logic ok;
      fork send_burst(2); join_none
      for (int i = 0; i < 3000 && !rx_valid; i++) @(negedge clk);
      held_d = rx_data; ok = rx_valid;
      repeat (60) begin
        @(negedge clk);
        if (!rx_valid || rx_data != held_d || tx_ready || !cs_n) ok = 1'b0;
      end
      check(ok, "R8 word held under back-pressure", rx_data, held_d);
      rx_ready = 1'b1;
      wait_idle();
      check(exp_rx.size() == 0, "R8 both words delivered", 32'(exp_rx.size()), 32'h0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule